// File: doc/BRIEF.md
# Dual-Read Register File

This block is the general-purpose register store of a small 32-bit RISC core. It holds 32 words of 32 bits. Two read ports, each with its own 5-bit index, return data combinationally. One write port with its own 5-bit index, a data word and an enable stores data on the falling clock edge.

The write commits in the middle of the cycle. A read in the second half of the same cycle therefore already returns the new word, so a result written back in one cycle can be read by the decode logic in that cycle without any forwarding path. Index 0 is tied to zero: it always reads as zero, and writes aimed at it are dropped.

A synchronous active-low reset clears the stored words. It is sampled on the same falling edge as writes and takes priority over them.

Top module: `regfile_dual_read`

## Requirements
- R1: The block stores 31 independent 32-bit words at indices 1 to 31, addressed by 5-bit indices. Each index returns the last word written to it.
- R2: A read port whose index is 0 returns 32'h0000_0000, on either port, at all times.
- R3: A write with index 0 and the enable high leaves every readable value unchanged; index 0 still reads zero afterwards.
- R4: A falling edge with the write enable low changes no stored word, whatever the write index and data are.
- R5: With the enable high and a nonzero index, the word is stored on the falling clock edge. A read of that index after that edge, within the same cycle, returns the new word.
- R6: The two read ports are independent: different indices on A and B return the two corresponding words at the same time.
- R7: When A and B carry the same index, both ports return identical data.
- R8: When the active-low reset is low at a falling edge, all words at indices 1 to 31 become zero. Reset takes priority over a write presented on the same edge.
- R9: Between the rising edge and the falling edge of a write cycle, a read of the target index still returns the previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset, sampled on the falling edge |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Index of the word to write |
| wr_data | input | 32 | Word to write |
| rd_idx_a | input | 5 | Index for read port A |
| rd_idx_b | input | 5 | Index for read port B |
| rd_data_a | output | 32 | Combinational read data, port A |
| rd_data_b | output | 32 | Combinational read data, port B |

## Verification
The checker assumes that the write controls, the read indices and the reset change only while the clock is high, well away from the falling edge. It also assumes that reset stays low across at least one falling edge. Under those assumptions, the value it records at a falling edge is still what the ports show at the following rising edge. The bench drives every input five nanoseconds after a rising edge, halfway through the high phase. It compares both read ports with its model just before and just after each falling edge. Reset is asserted and released only at those same drive points.

// File: rtl/regfile_pkg.sv
`timescale 1ns/1ps
// Package: regfile_pkg
// Shared sizing constants for the dual-read register file.
// Assumes the register count is a power of two so every index is valid.
package regfile_pkg;
    localparam int RF_WORDS = 32;
    localparam int RF_WIDTH = 32;
    localparam int RF_IDX_W = $clog2(RF_WORDS);
endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
// Module: rf_wr_decode
// Turns the write enable and write index into a one-hot word select.
// Slot 0 is never selected, so writes aimed at it are dropped here.
// Assumes NUM_WORDS == 2**IDX_W.
module rf_wr_decode #(
    parameter int NUM_WORDS = 32,
    parameter int IDX_W     = 5
) (
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    output logic [NUM_WORDS-1:0] wr_sel
);
    // Purpose: one-hot select of the target word, slot 0 masked off.
    always_comb begin
        wr_sel = '0;
        if (wr_en) begin
            wr_sel[wr_idx] = 1'b1;
        end
        wr_sel[0] = 1'b0;
    end
endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
// Module: rf_storage
// Holds the words of the register file in falling-edge flops.
// Slot 0 has no storage and is tied to zero.
// Reset is synchronous, active low, sampled on the falling edge, and
// has priority over a write on the same edge.
module rf_storage #(
    parameter int NUM_WORDS = 32,
    parameter int WIDTH     = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_WORDS-1:0]             wr_sel,
    input  logic [WIDTH-1:0]                 wr_data,
    output logic [NUM_WORDS-1:0][WIDTH-1:0]  bank
);
    logic unused_sel0;
    assign unused_sel0 = wr_sel[0];

    // Slot 0 is a constant zero.
    assign bank[0] = '0;

    for (genvar w = 1; w < NUM_WORDS; w++) begin : g_word
        logic [WIDTH-1:0] q;

        // Purpose: clear on reset, otherwise capture data when selected.
        always_ff @(negedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_sel[w]) begin
                q <= wr_data;
            end
        end

        assign bank[w] = q;
    end
endmodule

// File: rtl/rf_read_mux.sv
`timescale 1ns/1ps
// Module: rf_read_mux
// One combinational read port: selects a word from the bank by index.
// Index 0 is forced to zero here as well, independent of the bank.
// Assumes NUM_WORDS == 2**IDX_W.
module rf_read_mux #(
    parameter int NUM_WORDS = 32,
    parameter int WIDTH     = 32,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_WORDS-1:0][WIDTH-1:0] bank,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [WIDTH-1:0]                rd_data
);
    // Purpose: select the indexed word, zero for index 0.
    always_comb begin
        if (rd_idx == '0) begin
            rd_data = '0;
        end else begin
            rd_data = bank[rd_idx];
        end
    end
endmodule

// File: rtl/regfile_dual_read.sv
`timescale 1ns/1ps
// Module: regfile_dual_read
// Register file with two combinational read ports and one write port.
// Writes commit on the falling clock edge, so reads later in the same
// cycle see the new value. Index 0 always reads zero.
// Assumes inputs are stable around the falling edge.
module regfile_dual_read #(
    parameter int NUM_WORDS = regfile_pkg::RF_WORDS,
    parameter int WIDTH     = regfile_pkg::RF_WIDTH,
    parameter int IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    output logic [WIDTH-1:0] rd_data_a,
    output logic [WIDTH-1:0] rd_data_b
);
    localparam int NUM_PORTS = 2;

    logic [NUM_WORDS-1:0]            wr_sel;
    logic [NUM_WORDS-1:0][WIDTH-1:0] bank;
    logic [NUM_PORTS-1:0][IDX_W-1:0] port_idx;
    logic [NUM_PORTS-1:0][WIDTH-1:0] port_data;

    rf_wr_decode #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_dec (
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_sel (wr_sel)
    );

    rf_storage #(.NUM_WORDS(NUM_WORDS), .WIDTH(WIDTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .bank    (bank)
    );

    assign port_idx[0] = rd_idx_a;
    assign port_idx[1] = rd_idx_b;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rf_read_mux #(.NUM_WORDS(NUM_WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_mux (
            .bank    (bank),
            .rd_idx  (port_idx[p]),
            .rd_data (port_data[p])
        );
    end

    assign rd_data_a = port_data[0];
    assign rd_data_b = port_data[1];
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
// Module: rf_checker
// Assertions for regfile_dual_read, attached with bind.
// Records each falling-edge write and checks the ports at the next rising edge.
// Assumes inputs change only while the clock is high.
module rf_checker #(
    parameter int WIDTH = 32,
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [WIDTH-1:0] wr_data,
    input logic [IDX_W-1:0] rd_idx_a,
    input logic [IDX_W-1:0] rd_idx_b,
    input logic [WIDTH-1:0] rd_data_a,
    input logic [WIDTH-1:0] rd_data_b
);
    logic             seen_wr;
    logic             seen_rst;
    logic [IDX_W-1:0] seen_idx;
    logic [WIDTH-1:0] seen_data;
    logic [1:0]       warm;

    // Purpose: record what the last falling edge did.
    always_ff @(negedge clk) begin
        seen_rst  <= !rst_n;
        seen_wr   <= rst_n && wr_en && (wr_idx != '0);
        seen_idx  <= wr_idx;
        seen_data <= wr_data;
    end

    // Purpose: count rising edges since reset so $stable has history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm <= '0;
        end else if (warm != 2'd2) begin
            warm <= warm + 2'd1;
        end
    end

    AST_ZERO_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == '0) |-> (rd_data_a == '0)); // R2
    AST_ZERO_PORT_B: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_b == '0) |-> (rd_data_b == '0)); // R2
    AST_SAME_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx_a == rd_idx_b) |-> (rd_data_a == rd_data_b)); // R7
    AST_WRITE_SEEN_A: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wr && rd_idx_a == seen_idx) |-> (rd_data_a == seen_data)); // R5
    AST_WRITE_SEEN_B: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_wr && rd_idx_b == seen_idx) |-> (rd_data_b == seen_data)); // R5
    AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd2 && !seen_rst && $stable(rd_idx_a)
         && !(seen_wr && seen_idx == rd_idx_a)) |-> $stable(rd_data_a)); // R4
endmodule

bind regfile_dual_read rf_checker #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_rf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx_a  (rd_idx_a),
    .rd_idx_b  (rd_idx_b),
    .rd_data_a (rd_data_a),
    .rd_data_b (rd_data_b)
);

// File: tb/regfile_dual_read_bench.sv
`timescale 1ns/1ps
// Bench for regfile_dual_read: a behavioural model updated on each
// falling edge, compared with both read ports before and after it.
module regfile_dual_read_bench;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_idx_a = '0;
    logic [4:0]  rd_idx_b = '0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] model [32];

    regfile_dual_read u_regfile_dual_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_idx_a  (rd_idx_a),
        .rd_idx_b  (rd_idx_b),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    always #HALF clk = ~clk;

    // Reference model: reset wins, index 0 never stored.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) model[i] = 32'h0;
        end else if (wr_en && wr_idx != 5'd0) begin
            model[wr_idx] = wr_data;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
        return (32'(i) * 32'h0101_0101) ^ salt;
    endfunction

    // One cycle: drive mid-high phase, compare before and after the falling edge.
    task automatic step(input logic rst_v, input logic we, input logic [4:0] wi,
                        input logic [31:0] wd, input logic [4:0] ia, input logic [4:0] ib,
                        input string tag);
        @(posedge clk);
        #5ns;
        rst_n = rst_v; wr_en = we; wr_idx = wi; wr_data = wd;
        rd_idx_a = ia; rd_idx_b = ib;
        #3ns;
        if (rst_v) begin
            chk("R9 port A before edge", rd_data_a, model[ia]);
            chk("R9 port B before edge", rd_data_b, model[ib]);
        end
        @(negedge clk);
        #3ns;
        chk({tag, " port A"}, rd_data_a, model[ia]);
        chk({tag, " port B"}, rd_data_b, model[ib]);
    endtask

    initial begin
        #(HALF * 2 * 100000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired, all requirements incomplete");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // Reset state: R8
        step(1'b0, 1'b0, 5'd0, 32'h0, 5'd1, 5'd31, "R8 reset");
        step(1'b0, 1'b0, 5'd0, 32'h0, 5'd17, 5'd2, "R8 reset");
        chk("R8 reset clears word 17", rd_data_a, 32'h0);

        // Fill words 1..31, reading the target on A and its neighbour on B: R5, R6
        for (int i = 1; i < 32; i++) begin
            step(1'b1, 1'b1, 5'(i), pat(i, 32'hA5C3_0F00), 5'(i), 5'(i - 1), "R5 write then read");
            chk("R5 new word visible after falling edge", rd_data_a, pat(i, 32'hA5C3_0F00));
        end

        // Read back every pair: R1, R6
        for (int i = 0; i < 32; i++) begin
            step(1'b1, 1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i), "R1 R6 read pairs");
            if (i != 0) chk("R1 word kept", rd_data_a, pat(i, 32'hA5C3_0F00));
        end

        // Write aimed at index 0: R3, R2
        step(1'b1, 1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R3 write to zero");
        chk("R2 index 0 reads zero on A", rd_data_a, 32'h0);
        chk("R2 index 0 reads zero on B", rd_data_b, 32'h0);
        step(1'b1, 1'b0, 5'd0, 32'h0, 5'd1, 5'd0, "R3 neighbours unchanged");
        chk("R3 word 1 untouched", rd_data_a, pat(1, 32'hA5C3_0F00));

        // Enable low with live index and data: R4
        step(1'b1, 1'b0, 5'd5, 32'hDEAD_0000, 5'd5, 5'd6, "R4 disabled write");
        chk("R4 word 5 unchanged", rd_data_a, pat(5, 32'hA5C3_0F00));

        // Same index on both ports: R7
        step(1'b1, 1'b1, 5'd7, 32'h1234_5678, 5'd7, 5'd7, "R7 same index");
        chk("R7 ports agree", rd_data_b, rd_data_a);
        chk("R7 value", rd_data_b, 32'h1234_5678);

        // Back-to-back overwrites of word 31: R5, R9
        step(1'b1, 1'b1, 5'd31, 32'h0000_0001, 5'd31, 5'd30, "R5 overwrite");
        step(1'b1, 1'b1, 5'd31, 32'h8000_0000, 5'd31, 5'd31, "R5 overwrite");
        chk("R5 final overwrite", rd_data_a, 32'h8000_0000);

        // Reset with a write on the same edge: R8
        step(1'b0, 1'b1, 5'd9, 32'hCAFE_F00D, 5'd9, 5'd31, "R8 reset beats write");
        chk("R8 word 9 cleared", rd_data_a, 32'h0);
        step(1'b1, 1'b0, 5'd0, 32'h0, 5'd7, 5'd31, "R8 after reset");
        chk("R8 word 7 cleared", rd_data_a, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule